// File: doc/BRIEF.md
# Serial Configuration Frame Checker

This block consumes a serial configuration bitstream one bit per clock, qualified by a valid strobe. It skips idle '1' bits until it sees the first start bit. It then follows each frame: one start bit, a run of data bits whose length is set by an input, and four check bits. Each data bit is passed on with a strobe, and the check field of every frame is judged before the next frame is accepted.

Two checking styles are available. In pattern mode every frame must end in a fixed four-bit code. In CRC mode a single CRC-16 runs across all frames. Each ordinary frame is closed by a four-bit slice of that CRC. The last frame is closed by an eleven-bit slice that spans its final seven data bits as well as its check bits.

Any mismatch freezes the block. It stops passing data, pulls an active-low error flag down, and waits until a program pulse or reset starts it over. When the final frame passes, a one-cycle done pulse is given and further input is ignored.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset, err_no is high, done_o is low, dat_vld_o is low and frm_cnt_o is zero.
- R2: Valid '1' bits before the first start bit are skipped. A frame is a '0' start bit, frame_len_i data bits (frame_len_i of at least 8), then 4 check bits.
- R3: Each accepted data bit appears on dat_o, with dat_vld_o high for one cycle, on the cycle after it is accepted. Start, check, dummy and non-valid (vld_i low) bits are never strobed.
- R4: With crc_mode_i low, the check bits, first-received as MSB, must equal 4'b0110 (parameter EOF_PAT). Any number of valid '1' bits after a frame's check bits is skipped before the next start bit.
- R5: With crc_mode_i high, one CRC runs over the data bits of all frames. It uses polynomial 0x1021, a zero seed and serial input with feedback from bit 15. Check bits are not fed into it. On each non-final frame the 4 check bits, first-received first, must equal CRC bits 15 down to 12.
- R6: With crc_mode_i high, the CRC stops before the last seven data bits of the final frame. Those seven bits and the 4 check bits, taken in arrival order, must equal CRC bits 15 down to 5.
- R7: With crc_mode_i high, the bit after a non-final frame's check bits must be a '0' start bit. A '1' there is an error.
- R8: On an error, err_no falls on the cycle after the offending bit. It then stays low, no data is strobed and frm_cnt_o holds, until prog_i or reset.
- R9: frm_cnt_o rises by one on the cycle after each frame passes its check.
- R10: After the final frame (parameter NUM_FRAMES) passes, done_o is high for exactly one cycle. After that, input is ignored until prog_i.
- R11: prog_i high restarts the block on the next cycle. The error flag is cleared, frm_cnt_o becomes zero, the CRC becomes zero and hunting for a start bit begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial stream bit |
| vld_i | input | 1 | bit_i is valid this cycle |
| crc_mode_i | input | 1 | 1: CRC checking, 0: fixed pattern checking |
| prog_i | input | 1 | Synchronous restart |
| frame_len_i | input | LEN_W | Data bits per frame |
| dat_vld_o | output | 1 | Data bit strobe |
| dat_o | output | 1 | Data bit |
| frm_cnt_o | output | FCNT_W | Frames passed |
| err_no | output | 1 | Error flag, active low |
| done_o | output | 1 | Final frame passed, one-cycle pulse |

## Verification
The bound properties watch every cycle for the following. The error flag must stay low with no data strobes and a frozen frame count. The done pulse must last one cycle and be followed by silence. The frame count may only step by one. A program pulse must clear the state. Only the bench's streams can show that the right bits are strobed in order and that the CRC slices and fixed pattern are computed and compared correctly. The same holds for skipping dummy ones and for a flipped bit being caught at the end of the frame that carries it.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_DATA, ST_CHK, ST_SYNC, ST_WAIT, ST_DONE
  } fchk_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ (((c[15] ^ b) == 1'b1) ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
  import cfg_frame_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_step(crc_q, bit_i);
  end
  assign crc_o = crc_q;
endmodule

// File: rtl/cfg_tail_sreg.sv
module cfg_tail_sreg #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (en_i)  q <= {q[W-2:0], bit_i};
  end
  assign q_o = q;
endmodule

// File: rtl/cfg_check_cmp.sv
module cfg_check_cmp #(
  parameter logic [3:0] EOF_PAT = 4'b0110,
  parameter int         TAIL_W  = 11
) (
  input  logic              crc_mode_i,
  input  logic              last_i,
  input  logic [15:0]       crc_i,
  input  logic [TAIL_W-2:0] hist_i,
  input  logic              bit_i,
  output logic              ok_o
);
  logic [TAIL_W-1:0] rx;
  always_comb begin
    rx = {hist_i, bit_i};
    if (!crc_mode_i)  ok_o = (rx[3:0] == EOF_PAT);
    else if (last_i)  ok_o = (rx == crc_i[15:16-TAIL_W]);
    else              ok_o = (rx[3:0] == crc_i[15:12]);
  end
endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
  import cfg_frame_pkg::*;
#(
  parameter int         LEN_W      = 12,
  parameter int         NUM_FRAMES = 4,
  parameter logic [3:0] EOF_PAT    = 4'b0110,
  localparam int        FCNT_W     = $clog2(NUM_FRAMES + 1),
  localparam int        OVL        = 7,
  localparam int        TAIL_W     = OVL + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              vld_i,
  input  logic              crc_mode_i,
  input  logic              prog_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  output logic              dat_vld_o,
  output logic              dat_o,
  output logic [FCNT_W-1:0] frm_cnt_o,
  output logic              err_no,
  output logic              done_o
);
  fchk_state_e       st_q, st_d;
  logic [LEN_W-1:0]  pos_q, pos_d;
  logic [1:0]        cpos_q, cpos_d;
  logic [FCNT_W-1:0] frm_q, frm_d;
  logic              err_nq, err_nd, done_q, done_d, dvld_q, dvld_d, dat_q, dat_d;
  logic              last_frm, tail_zone, crc_en, hist_en, chk_ok, done_st;
  logic [15:0]       crc;
  logic [TAIL_W-2:0] hist;

  assign last_frm  = (frm_q == FCNT_W'(NUM_FRAMES - 1));
  assign tail_zone = crc_mode_i && last_frm && (pos_q >= frame_len_i - LEN_W'(OVL));
  assign crc_en    = vld_i && !prog_i && (st_q == ST_DATA) && !tail_zone;
  assign hist_en   = vld_i && !prog_i && ((st_q == ST_DATA) || (st_q == ST_CHK));
  assign done_st   = (st_q == ST_DONE);

  cfg_crc_acc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(prog_i), .en_i(crc_en),
    .bit_i(bit_i), .crc_o(crc)
  );

  cfg_tail_sreg #(.W(TAIL_W - 1)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(prog_i), .en_i(hist_en),
    .bit_i(bit_i), .q_o(hist)
  );

  cfg_check_cmp #(.EOF_PAT(EOF_PAT), .TAIL_W(TAIL_W)) u_cmp (
    .crc_mode_i(crc_mode_i), .last_i(last_frm), .crc_i(crc),
    .hist_i(hist), .bit_i(bit_i), .ok_o(chk_ok)
  );

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    cpos_d = cpos_q;
    frm_d  = frm_q;
    err_nd = err_nq;
    done_d = 1'b0;
    dvld_d = 1'b0;
    dat_d  = dat_q;
    if (prog_i) begin
      st_d   = ST_HUNT;
      pos_d  = '0;
      cpos_d = '0;
      frm_d  = '0;
      err_nd = 1'b1;
    end else if (vld_i) begin
      unique case (st_q)
        ST_HUNT: if (!bit_i) begin
          st_d  = ST_DATA;
          pos_d = '0;
        end
        ST_SYNC: begin
          if (!bit_i) begin
            st_d  = ST_DATA;
            pos_d = '0;
          end else begin
            st_d   = ST_WAIT;
            err_nd = 1'b0;
          end
        end
        ST_DATA: begin
          dvld_d = 1'b1;
          dat_d  = bit_i;
          if (pos_q == frame_len_i - LEN_W'(1)) begin
            st_d   = ST_CHK;
            cpos_d = '0;
          end else begin
            pos_d = pos_q + LEN_W'(1);
          end
        end
        ST_CHK: begin
          cpos_d = cpos_q + 2'd1;
          if (cpos_q == 2'd3) begin
            if (chk_ok) begin
              frm_d = frm_q + FCNT_W'(1);
              if (last_frm) begin
                st_d   = ST_DONE;
                done_d = 1'b1;
              end else begin
                st_d = crc_mode_i ? ST_SYNC : ST_HUNT;
              end
            end else begin
              st_d   = ST_WAIT;
              err_nd = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      cpos_q <= '0;
      frm_q  <= '0;
      err_nq <= 1'b1;
      done_q <= 1'b0;
      dvld_q <= 1'b0;
      dat_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      cpos_q <= cpos_d;
      frm_q  <= frm_d;
      err_nq <= err_nd;
      done_q <= done_d;
      dvld_q <= dvld_d;
      dat_q  <= dat_d;
    end
  end

  assign dat_vld_o = dvld_q;
  assign dat_o     = dat_q;
  assign frm_cnt_o = frm_q;
  assign err_no    = err_nq;
  assign done_o    = done_q;
endmodule

// File: rtl/cfg_frame_checker_sva.sv
module cfg_frame_checker_sva #(
  parameter int FCNT_W     = 3,
  parameter int NUM_FRAMES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_i,
  input logic              err_no,
  input logic              dat_vld_o,
  input logic              done_o,
  input logic [FCNT_W-1:0] frm_cnt_o,
  input logic              in_done
);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_no && !prog_i) |=> !err_no);
  assert_no_strobe_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_no |-> !dat_vld_o);
  assert_cnt_hold_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_no && !prog_i) |=> $stable(frm_cnt_o));
  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |=> (frm_cnt_o == $past(frm_cnt_o)) || (frm_cnt_o == $past(frm_cnt_o) + FCNT_W'(1)));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_no && frm_cnt_o == FCNT_W'(NUM_FRAMES)));
  assert_idle_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_done && !prog_i) |=> (!dat_vld_o && $stable(frm_cnt_o)));
  assert_prog_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (err_no && frm_cnt_o == '0 && !done_o));
endmodule

bind cfg_frame_checker cfg_frame_checker_sva #(
  .FCNT_W(FCNT_W), .NUM_FRAMES(NUM_FRAMES)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(prog_i), .err_no(err_no),
  .dat_vld_o(dat_vld_o), .done_o(done_o), .frm_cnt_o(frm_cnt_o), .in_done(done_st)
);

// File: tb/cfg_frame_checker_tb.sv
`timescale 1ns/1ps
module cfg_frame_checker_tb;
  localparam int NF = 4;
  localparam int LEN = 12;
  localparam logic [3:0] PAT = 4'b0110;

  logic clk_i = 1'b0, rst_ni = 1'b0, bit_i = 1'b1, vld_i = 1'b0, crc_mode_i = 1'b0, prog_i = 1'b0;
  logic [11:0] frame_len_i = 12'(LEN);
  logic dat_vld_o, dat_o, err_no, done_o;
  logic [2:0] frm_cnt_o;

  cfg_frame_checker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .vld_i(vld_i), .crc_mode_i(crc_mode_i),
    .prog_i(prog_i), .frame_len_i(frame_len_i), .dat_vld_o(dat_vld_o), .dat_o(dat_o),
    .frm_cnt_o(frm_cnt_o), .err_no(err_no), .done_o(done_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, done_seen = 0;
  bit stream_q[$];
  bit exp_q[$];
  logic dat_a [NF][LEN];
  logic [3:0] chk_a [NF];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) done_seen++;
      if (dat_vld_o) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected strobe", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(dat_o == e, "R3 data bit", int'(dat_o), int'(e));
        end
      end
    end
  end

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic gen(input bit md);
    logic [15:0] c = '0;
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < LEN; i++) begin
        if (md && f == NF-1 && i >= LEN-7) dat_a[f][i] = c[15-(i-(LEN-7))];
        else begin
          dat_a[f][i] = 1'($urandom % 2);
          c = crc_step(c, dat_a[f][i]);
        end
      end
      if (!md) chk_a[f] = PAT;
      else if (f == NF-1) chk_a[f] = c[8:5];
      else chk_a[f] = c[15:12];
    end
  endtask

  // first frame that fails, NF when all pass
  function automatic int ref_fail(input bit md);
    logic [15:0] c = '0;
    logic [10:0] rx;
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < LEN; i++)
        if (!(md && f == NF-1 && i >= LEN-7)) c = crc_step(c, dat_a[f][i]);
      if (!md) begin
        if (chk_a[f] != PAT) return f;
      end else if (f == NF-1) begin
        for (int i = 0; i < 7; i++) rx[10-i] = dat_a[f][LEN-7+i];
        rx[3:0] = chk_a[f];
        if (rx != c[15:5]) return f;
      end else if (chk_a[f] != c[15:12]) return f;
    end
    return NF;
  endfunction

  task automatic build(input bit md, input int nlead, input int ntrail, input bit gap_bad, input int failf);
    stream_q.delete();
    for (int i = 0; i < nlead; i++) stream_q.push_back(1'b1);
    for (int f = 0; f < NF; f++) begin
      stream_q.push_back(1'b0);
      for (int i = 0; i < LEN; i++) begin
        stream_q.push_back(dat_a[f][i]);
        if (f <= failf) exp_q.push_back(dat_a[f][i]);
      end
      for (int b = 3; b >= 0; b--) stream_q.push_back(chk_a[f][b]);
      if (f < NF-1 && !md) for (int i = 0; i < ntrail; i++) stream_q.push_back(1'b1);
      if (f == 0 && md && gap_bad) stream_q.push_back(1'b1);
    end
  endtask

  task automatic drive();
    foreach (stream_q[k]) begin
      if ($urandom % 4 == 0) begin
        @(negedge clk_i); vld_i = 1'b0; bit_i = 1'($urandom % 2);
      end
      @(negedge clk_i); vld_i = 1'b1; bit_i = stream_q[k];
    end
    @(negedge clk_i); vld_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic prog_pulse();
    @(negedge clk_i); prog_i = 1'b1;
    @(negedge clk_i); prog_i = 1'b0;
    check(err_no == 1'b1, "R11 err cleared", int'(err_no), 1);
    check(frm_cnt_o == 0, "R11 count cleared", int'(frm_cnt_o), 0);
    exp_q.delete();
    done_seen = 0;
  endtask

  task automatic extra_bits();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); vld_i = 1'b1; bit_i = 1'(i % 3 == 0 ? 0 : 1);
    end
    @(negedge clk_i); vld_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run(input bit md, input int nlead, input int ntrail, input bit gap_bad,
                     input int failf, input string req);
    int exp_cnt;
    crc_mode_i = md;
    build(md, nlead, ntrail, gap_bad, gap_bad ? 0 : failf);
    drive();
    exp_cnt = gap_bad ? 1 : failf;
    check(exp_q.size() == 0, {req, " all data strobed"}, exp_q.size(), 0);
    if (!gap_bad && failf == NF) begin
      check(err_no == 1'b1, {req, " no error"}, int'(err_no), 1);
      check(done_seen == 1, "R10 done pulse", done_seen, 1);
      check(frm_cnt_o == NF, "R9 frame count", int'(frm_cnt_o), NF);
      extra_bits();
      check(frm_cnt_o == NF, "R10 ignored after done", int'(frm_cnt_o), NF);
      check(done_seen == 1, "R10 single done", done_seen, 1);
    end else begin
      check(err_no == 1'b0, {req, " error flagged"}, int'(err_no), 0);
      check(done_seen == 0, "R8 no done", done_seen, 0);
      check(frm_cnt_o == exp_cnt, "R8 count at failing frame", int'(frm_cnt_o), exp_cnt);
      extra_bits();
      check(err_no == 1'b0, "R8 error sticky", int'(err_no), 0);
      check(frm_cnt_o == exp_cnt, "R8 count held", int'(frm_cnt_o), exp_cnt);
    end
    prog_pulse();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(err_no == 1'b1, "R1 err_no", int'(err_no), 1);
    check(done_o == 1'b0, "R1 done_o", int'(done_o), 0);
    check(dat_vld_o == 1'b0, "R1 dat_vld_o", int'(dat_vld_o), 0);
    check(frm_cnt_o == 0, "R1 frm_cnt_o", int'(frm_cnt_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R4: pattern mode with leading and trailing dummy ones
    gen(1'b0); run(1'b0, 3, 2, 1'b0, NF, "R4");
    gen(1'b0); run(1'b0, 0, 0, 1'b0, NF, "R2");
    // R4: corrupted pattern in frame 2
    gen(1'b0); chk_a[2][1] = ~chk_a[2][1];
    run(1'b0, 1, 1, 1'b0, ref_fail(1'b0), "R4 bad pattern");
    // R5 R6: clean CRC stream
    gen(1'b1); run(1'b1, 2, 0, 1'b0, NF, "R5 R6");
    // R5: one data bit flipped per frame
    for (int f = 0; f < NF - 1; f++) begin
      gen(1'b1); dat_a[f][2] = ~dat_a[f][2];
      run(1'b1, 1, 0, 1'b0, ref_fail(1'b1), "R5 flipped data");
    end
    // R5: flipped check bit
    gen(1'b1); chk_a[1][0] = ~chk_a[1][0];
    run(1'b1, 0, 0, 1'b0, ref_fail(1'b1), "R5 flipped check");
    // R6: flipped bit inside final frame overlap
    gen(1'b1); dat_a[NF-1][LEN-2] = ~dat_a[NF-1][LEN-2];
    run(1'b1, 0, 0, 1'b0, ref_fail(1'b1), "R6 overlap");
    gen(1'b1); dat_a[NF-1][1] = ~dat_a[NF-1][1];
    run(1'b1, 0, 0, 1'b0, ref_fail(1'b1), "R6 early data");
    // R7: stray one after frame 0 in CRC mode
    gen(1'b1); run(1'b1, 0, 0, 1'b1, 0, "R7 gap");
    finish_up();
  end
endmodule